// File: doc/BRIEF.md
# Write Strobe Lane Checker

This passive monitor watches the write address and write data channels of a bus with a 64-bit data path. It never drives the bus. It records the burst attributes when a write address handshake completes. For every accepted data beat it works out the address of that beat and the byte lanes the beat is allowed to enable. A strobe bit outside that set raises a one-cycle error flag, and the flag reports the index of the offending beat.

Only the first beat of a burst may start partway into its container. Every later beat covers a full, size-aligned container. A fixed burst keeps the same lanes on every beat, and a wrapping burst folds its beat addresses back inside its wrap boundary. Inside the allowed lanes any pattern is accepted, including sparse ones and an all-zero strobe. The monitor also flags a wrapping burst whose start address is not aligned to the transfer size, and a last-beat marker that arrives on the wrong beat.

The control is a two-state machine:
- `ST_IDLE` waits for an address.
- `ST_BURST` counts data beats.
- `ADDR_TAKEN` moves `ST_IDLE` to `ST_BURST` on an address handshake.
- `LAST_BEAT` moves `ST_BURST` back to `ST_IDLE` on a data handshake that carries the last-beat marker.

The monitor tracks one burst at a time. A data beat is checked only from the cycle after its address was taken.

Top module: `wstrb_lane_monitor`

## Requirements
- R1: After reset, `err_lane`, `err_last` and `err_wrap` are low and `err_beat` is 0.
- R2: Burst attributes are captured only when `aw_valid` and `aw_ready` are both high in `ST_IDLE`. An address offered while a burst is open is ignored, and so is an address without `aw_ready`. A data beat seen in `ST_IDLE` raises no flag.
- R3: On beat 0 the allowed lanes run from lane `addr mod 8` up to the last lane of the size-aligned container that holds that address. With size 3 (8 bytes) and address 0x1, strobe 0xFE is accepted and strobe 0xFF is flagged, because lane 0 lies below the start.
- R4: A narrow transfer is limited to its container. With size 2 (4 bytes) at address 0x1, only lanes 3..1 are allowed, so 0x0E is accepted and 0x10 and 0x01 are flagged.
- R5: In an incrementing burst (`aw_burst` = 2'b01; 2'b11 is treated the same way), beat n > 0 uses address `align(addr, 2^size) + n*2^size` and the whole container at that address.
- R6: In a fixed burst (`aw_burst` = 2'b00), every beat uses the beat-0 lane set, including the unaligned start.
- R7: In a wrapping burst (`aw_burst` = 2'b10), the beat address is `base + ((aligned_start + n*2^size) mod span)`. Here `span = (len+1)*2^size` and `base` is the start address aligned to `span`.
- R8: An address handshake for a wrapping burst whose address is not a multiple of `2^size` raises `err_wrap` in the next cycle. An aligned wrapping burst, or an unaligned burst of another type, does not raise it.
- R9: Sparse strobes (for example 0x05, 0x0A, 0x09, 0x19) and an all-zero strobe are accepted whenever every set bit lies inside the allowed lanes.
- R10: A data beat that carries `w_last` on a beat index other than `aw_len` raises `err_last`, and the burst then closes.
- R11: Every flag is high for exactly the one cycle after the handshake that caused it. When `err_lane` or `err_last` is high, `err_beat` holds the 0-based index of that beat.
- R12: The beat carrying `w_last` returns the monitor to `ST_IDLE`. The next burst starts counting again at beat 0, using its own newly captured attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write start address |
| aw_size | input | 3 | Bytes per beat as log2 |
| aw_len | input | 8 | Beats in the burst minus one |
| aw_burst | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_strb | input | BUS_BYTES | Byte lane strobes |
| w_last | input | 1 | Last beat marker |
| err_lane | output | 1 | Strobe outside the allowed lanes |
| err_last | output | 1 | Last-beat marker on the wrong beat |
| err_wrap | output | 1 | Unaligned wrapping start address |
| err_beat | output | 8 | Beat index of the last lane or last-beat error |

## Verification
The case hardest to reach from the ports is a wrapping burst whose wrap span is narrower than the data bus. Only then does the folded beat address land on different lanes than an incrementing burst would reach. The stimulus reaches it with byte-sized and halfword-sized two-beat wrapping bursts, so the wrapped lane and the incrementing lane differ. It then places a strobe that only the incrementing sequence would allow. A second hard case is an address offered while a burst is still open. The bench offers a conflicting address mid-burst, then sends strobes that are legal only under the first address.

// File: rtl/wstrb_mon_pkg.sv
package wstrb_mon_pkg;

    localparam int unsigned LEN_W  = 8;
    localparam int unsigned SIZE_W = 3;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10,
        BURST_RSVD  = 2'b11
    } burst_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } mon_state_e;

endpackage

// File: rtl/wstrb_burst_fsm.sv
module wstrb_burst_fsm
    import wstrb_mon_pkg::*;
#(
    parameter int unsigned OFF_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_fire,
    input  logic [OFF_W-1:0]  aw_off,
    input  logic [SIZE_W-1:0] aw_size_eff,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [1:0]        aw_burst,
    input  logic              w_fire,
    input  logic              w_last,
    output logic              busy,
    output logic              take,
    output logic              beat_fire,
    output logic [OFF_W-1:0]  ctx_off,
    output logic [SIZE_W-1:0] ctx_size,
    output logic [LEN_W-1:0]  ctx_len,
    output burst_e            ctx_burst,
    output logic [LEN_W-1:0]  beat_idx
);

    mon_state_e state_q, state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (aw_fire)           state_d = ST_BURST; // ADDR_TAKEN
            ST_BURST: if (w_fire && w_last)  state_d = ST_IDLE;  // LAST_BEAT
            default:                         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        busy      = (state_q == ST_BURST);
        take      = (state_q == ST_IDLE) && aw_fire;
        beat_fire = (state_q == ST_BURST) && w_fire;
    end

    // burst context and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_off   <= '0;
            ctx_size  <= '0;
            ctx_len   <= '0;
            ctx_burst <= BURST_INCR;
            beat_idx  <= '0;
        end else begin
            if (take) begin
                ctx_off   <= aw_off;
                ctx_size  <= aw_size_eff;
                ctx_len   <= aw_len;
                ctx_burst <= burst_e'(aw_burst);
                beat_idx  <= '0;
            end else if (beat_fire) begin
                beat_idx  <= w_last ? '0 : beat_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wstrb_beat_addr.sv
module wstrb_beat_addr
    import wstrb_mon_pkg::*;
#(
    parameter int unsigned OFF_W = 12
) (
    input  logic [OFF_W-1:0]  start_off,
    input  logic [SIZE_W-1:0] size,
    input  logic [LEN_W-1:0]  len,
    input  burst_e            burst,
    input  logic [LEN_W-1:0]  beat,
    output logic [OFF_W-1:0]  beat_off
);

    logic [OFF_W-1:0] unit;
    logic [OFF_W-1:0] aligned;
    logic [OFF_W-1:0] step;
    logic [OFF_W-1:0] span_mask;
    logic [OFF_W-1:0] linear;

    always_comb begin
        unit      = OFF_W'(1) << size;
        aligned   = start_off & ~(unit - OFF_W'(1));
        step      = OFF_W'(beat) << size;
        span_mask = ((OFF_W'(len) + OFF_W'(1)) << size) - OFF_W'(1);
        linear    = aligned + step;
        if (beat == '0) begin
            beat_off = start_off;
        end else begin
            unique case (burst)
                BURST_FIXED: beat_off = start_off;
                BURST_WRAP:  beat_off = (aligned & ~span_mask) | (linear & span_mask);
                BURST_INCR,
                BURST_RSVD:  beat_off = linear;
                default:     beat_off = linear;
            endcase
        end
    end

endmodule

// File: rtl/wstrb_lane_mask.sv
module wstrb_lane_mask
    import wstrb_mon_pkg::*;
#(
    parameter int unsigned BUS_BYTES = 8,
    localparam int unsigned LANE_W   = $clog2(BUS_BYTES)
) (
    input  logic [LANE_W-1:0]    lane_lo,
    input  logic [SIZE_W-1:0]    size,
    output logic [BUS_BYTES-1:0] permit
);

    logic [LANE_W:0] unit;
    logic [LANE_W:0] base;
    logic [LANE_W:0] stop;

    always_comb begin
        unit = (LANE_W+1)'(1) << size;
        base = {1'b0, lane_lo} & ~(unit - (LANE_W+1)'(1));
        stop = base + unit;
    end

    for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
        assign permit[g] = ((LANE_W+1)'(g) >= {1'b0, lane_lo}) &&
                           ((LANE_W+1)'(g) <  stop);
    end

endmodule

// File: rtl/wstrb_lane_monitor.sv
module wstrb_lane_monitor
    import wstrb_mon_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BUS_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 aw_valid,
    input  logic                 aw_ready,
    input  logic [ADDR_W-1:0]    aw_addr,
    input  logic [2:0]           aw_size,
    input  logic [7:0]           aw_len,
    input  logic [1:0]           aw_burst,
    input  logic                 w_valid,
    input  logic                 w_ready,
    input  logic [BUS_BYTES-1:0] w_strb,
    input  logic                 w_last,
    output logic                 err_lane,
    output logic                 err_last,
    output logic                 err_wrap,
    output logic [7:0]           err_beat
);

    localparam int unsigned LANE_W   = $clog2(BUS_BYTES);
    localparam int unsigned MAX_SIZE = LANE_W;
    localparam int unsigned OFF_W    = LANE_W + LEN_W + 1;

    logic              aw_fire, w_fire;
    logic [SIZE_W-1:0] size_eff;
    logic              busy, take, beat_fire;
    logic [OFF_W-1:0]  ctx_off, beat_off;
    logic [SIZE_W-1:0] ctx_size;
    logic [LEN_W-1:0]  ctx_len, beat_idx;
    burst_e            ctx_burst;
    logic [BUS_BYTES-1:0] permit;
    logic [LANE_W-1:0] wrap_low_mask;
    logic              lane_bad, last_bad, wrap_bad;

    assign aw_fire  = aw_valid && aw_ready;
    assign w_fire   = w_valid && w_ready;
    assign size_eff = (aw_size > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : aw_size;

    wstrb_burst_fsm #(.OFF_W(OFF_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .aw_fire     (aw_fire),
        .aw_off      (aw_addr[OFF_W-1:0]),
        .aw_size_eff (size_eff),
        .aw_len      (aw_len),
        .aw_burst    (aw_burst),
        .w_fire      (w_fire),
        .w_last      (w_last),
        .busy        (busy),
        .take        (take),
        .beat_fire   (beat_fire),
        .ctx_off     (ctx_off),
        .ctx_size    (ctx_size),
        .ctx_len     (ctx_len),
        .ctx_burst   (ctx_burst),
        .beat_idx    (beat_idx)
    );

    wstrb_beat_addr #(.OFF_W(OFF_W)) u_addr (
        .start_off (ctx_off),
        .size      (ctx_size),
        .len       (ctx_len),
        .burst     (ctx_burst),
        .beat      (beat_idx),
        .beat_off  (beat_off)
    );

    wstrb_lane_mask #(.BUS_BYTES(BUS_BYTES)) u_mask (
        .lane_lo (beat_off[LANE_W-1:0]),
        .size    (ctx_size),
        .permit  (permit)
    );

    always_comb begin
        wrap_low_mask = LANE_W'(((LANE_W+1)'(1) << size_eff) - (LANE_W+1)'(1));
        lane_bad = beat_fire && |(w_strb & ~permit);
        last_bad = beat_fire && w_last && (beat_idx != ctx_len);
        wrap_bad = take && (aw_burst == BURST_WRAP) &&
                   |(aw_addr[LANE_W-1:0] & wrap_low_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_lane <= 1'b0;
            err_last <= 1'b0;
            err_wrap <= 1'b0;
            err_beat <= '0;
        end else begin
            err_lane <= lane_bad;
            err_last <= last_bad;
            err_wrap <= wrap_bad;
            if (lane_bad || last_bad) err_beat <= beat_idx;
        end
    end

endmodule

// File: rtl/wstrb_lane_monitor_chk.sv
module wstrb_lane_monitor_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BUS_BYTES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 aw_valid,
    input logic                 aw_ready,
    input logic [ADDR_W-1:0]    aw_addr,
    input logic [1:0]           aw_burst,
    input logic                 w_valid,
    input logic                 w_ready,
    input logic [BUS_BYTES-1:0] w_strb,
    input logic                 w_last,
    input logic                 busy,
    input logic                 err_lane,
    input logic                 err_last,
    input logic                 err_wrap
);

    assert_take_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready && !busy) |=> busy);

    assert_lane_after_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_lane |-> $past(w_valid && w_ready && busy));

    assert_wrap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_wrap |-> $past(aw_valid && aw_ready && !busy && aw_burst == 2'b10));

    assert_aligned_wrap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && aw_ready && !busy && aw_addr[2:0] == 3'b000) |=> !err_wrap);

    assert_zero_strobe_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && busy && w_strb == '0) |=> !err_lane);

    assert_last_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_last |-> $past(w_valid && w_ready && busy && w_last));

    assert_last_closes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && busy && w_last) |=> !busy);

endmodule

bind wstrb_lane_monitor wstrb_lane_monitor_chk #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .aw_addr  (aw_addr),
    .aw_burst (aw_burst),
    .w_valid  (w_valid),
    .w_ready  (w_ready),
    .w_strb   (w_strb),
    .w_last   (w_last),
    .busy     (busy),
    .err_lane (err_lane),
    .err_last (err_last),
    .err_wrap (err_wrap)
);

// File: tb/tb_wstrb_lane_monitor.sv
module tb_wstrb_lane_monitor;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw_valid = 1'b0, aw_ready = 1'b0;
    logic [31:0] aw_addr = '0;
    logic [2:0]  aw_size = '0;
    logic [7:0]  aw_len = '0;
    logic [1:0]  aw_burst = '0;
    logic        w_valid = 1'b0, w_ready = 1'b1;
    logic [7:0]  w_strb = '0;
    logic        w_last = 1'b0;
    logic        err_lane, err_last, err_wrap;
    logic [7:0]  err_beat;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wstrb_lane_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .aw_size(aw_size), .aw_len(aw_len), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_strb(w_strb), .w_last(w_last),
        .err_lane(err_lane), .err_last(err_last), .err_wrap(err_wrap),
        .err_beat(err_beat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_aw(input logic [31:0] a, input logic [2:0] s, input logic [7:0] l,
                         input logic [1:0] b, input logic rdy, input logic exp_wrap,
                         input string tag);
        @(negedge clk);
        aw_valid = 1'b1; aw_ready = rdy;
        aw_addr = a; aw_size = s; aw_len = l; aw_burst = b;
        @(negedge clk);
        aw_valid = 1'b0; aw_ready = 1'b0;
        chk({tag, " err_wrap"}, 32'(err_wrap), 32'(exp_wrap));
    endtask

    task automatic do_w(input logic [7:0] s, input logic last, input logic exp_lane,
                        input logic exp_last, input logic [7:0] exp_beat, input string tag);
        @(negedge clk);
        w_valid = 1'b1; w_strb = s; w_last = last;
        @(negedge clk);
        w_valid = 1'b0; w_last = 1'b0;
        chk({tag, " err_lane"}, 32'(err_lane), 32'(exp_lane));
        chk({tag, " err_last"}, 32'(err_last), 32'(exp_last));
        if (exp_lane || exp_last)
            chk({tag, " err_beat"}, 32'(err_beat), 32'(exp_beat));
    endtask

    task automatic t_reset_R1;
        chk("R1 err_lane", 32'(err_lane), 0);
        chk("R1 err_last", 32'(err_last), 0);
        chk("R1 err_wrap", 32'(err_wrap), 0);
        chk("R1 err_beat", 32'(err_beat), 0);
    endtask

    task automatic t_first_beat_R3;
        do_aw(32'h1001, 3, 0, 2'b01, 1, 0, "R3 aw");
        do_w(8'hFF, 1, 1, 0, 0, "R3 lane0 below start");
        @(negedge clk);
        chk("R11 lane flag one cycle", 32'(err_lane), 0);
        do_aw(32'h1001, 3, 0, 2'b01, 1, 0, "R3 aw2");
        do_w(8'hFE, 1, 0, 0, 0, "R3 lanes 7..1");
    endtask

    task automatic t_narrow_R4;
        do_aw(32'h1, 2, 0, 2'b01, 1, 0, "R4 aw");
        do_w(8'h0E, 1, 0, 0, 0, "R4 lanes 3..1");
        do_aw(32'h1, 2, 0, 2'b01, 1, 0, "R4 aw2");
        do_w(8'h10, 1, 1, 0, 0, "R4 lane4 outside");
        do_aw(32'h1, 2, 0, 2'b01, 1, 0, "R4 aw3");
        do_w(8'h01, 1, 1, 0, 0, "R4 lane0 below");
    endtask

    task automatic t_incr_R5;
        do_aw(32'h1, 2, 3, 2'b01, 1, 0, "R5 aw");
        do_w(8'h0E, 0, 0, 0, 0, "R5 beat0");
        do_w(8'hF0, 0, 0, 0, 0, "R5 beat1 addr4");
        do_w(8'h0F, 0, 0, 0, 0, "R5 beat2 addr8");
        do_w(8'h0F, 1, 1, 0, 3, "R5 beat3 addr12");
    endtask

    task automatic t_fixed_R6;
        do_aw(32'h2, 1, 2, 2'b00, 1, 0, "R6 aw");
        do_w(8'h0C, 0, 0, 0, 0, "R6 beat0");
        do_w(8'h04, 0, 0, 0, 0, "R6 beat1");
        do_w(8'h30, 1, 1, 0, 2, "R6 beat2 outside");
        do_aw(32'h3, 1, 1, 2'b00, 1, 0, "R6 aw2");
        do_w(8'h08, 0, 0, 0, 0, "R6 unaligned beat0");
        do_w(8'h04, 1, 1, 0, 1, "R6 unaligned kept beat1");
    endtask

    task automatic t_wrap_R7;
        do_aw(32'h8, 2, 3, 2'b10, 1, 0, "R7 aw");
        do_w(8'h0F, 0, 0, 0, 0, "R7 beat0 addr8");
        do_w(8'hF0, 0, 0, 0, 0, "R7 beat1 addr12");
        do_w(8'h0F, 0, 0, 0, 0, "R7 beat2 addr0");
        do_w(8'hF0, 1, 0, 0, 0, "R7 beat3 addr4");
        do_aw(32'h3, 0, 1, 2'b10, 1, 0, "R7 aw2");
        do_w(8'h08, 0, 0, 0, 0, "R7 byte beat0");
        do_w(8'h10, 1, 1, 0, 1, "R7 byte wrapped to lane2");
        do_aw(32'h6, 1, 1, 2'b10, 1, 0, "R7 aw3");
        do_w(8'hC0, 0, 0, 0, 0, "R7 half beat0");
        do_w(8'h30, 1, 0, 0, 0, "R7 half wrapped to addr4");
    endtask

    task automatic t_wrap_align_R8;
        do_aw(32'h2, 2, 1, 2'b10, 1, 1, "R8 unaligned wrap");
        @(negedge clk);
        chk("R11 wrap flag one cycle", 32'(err_wrap), 0);
        do_w(8'h00, 0, 0, 0, 0, "R8 beat0");
        do_w(8'h00, 1, 0, 0, 0, "R8 beat1");
    endtask

    task automatic t_sparse_R9;
        do_aw(32'h0, 3, 4, 2'b01, 1, 0, "R9 aw");
        do_w(8'h05, 0, 0, 0, 0, "R9 0x05");
        do_w(8'h0A, 0, 0, 0, 0, "R9 0x0A");
        do_w(8'h09, 0, 0, 0, 0, "R9 0x09");
        do_w(8'h19, 0, 0, 0, 0, "R9 0x19");
        do_w(8'h00, 1, 0, 0, 0, "R9 zero");
    endtask

    task automatic t_early_last_R10;
        do_aw(32'h0, 3, 2, 2'b01, 1, 0, "R10 aw");
        do_w(8'h01, 1, 0, 1, 0, "R10 last on beat0");
        @(negedge clk);
        chk("R11 last flag one cycle", 32'(err_last), 0);
    endtask

    task automatic t_restart_R12;
        do_aw(32'h4, 3, 0, 2'b01, 1, 0, "R12 aw");
        do_w(8'h08, 1, 1, 0, 0, "R12 new burst beat0");
    endtask

    task automatic t_idle_R2;
        do_w(8'hFF, 1, 0, 0, 0, "R2 beat while idle");
        do_aw(32'h1, 3, 0, 2'b01, 0, 0, "R2 aw not ready");
        do_w(8'hFF, 1, 0, 0, 0, "R2 still idle");
        do_aw(32'h0, 3, 1, 2'b01, 1, 0, "R2 aw");
        do_aw(32'h7, 3, 0, 2'b10, 1, 0, "R2 aw while busy");
        do_w(8'hFF, 0, 0, 0, 0, "R2 first attrs kept beat0");
        do_w(8'hFF, 1, 0, 0, 0, "R2 first len kept beat1");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_R1;
        t_first_beat_R3;
        t_narrow_R4;
        t_incr_R5;
        t_fixed_R6;
        t_wrap_R7;
        t_wrap_align_R8;
        t_sparse_R9;
        t_early_last_R10;
        t_restart_R12;
        t_idle_R2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule